// File: doc/BRIEF.md
# Shared Frontend Miss Tracker

This block attributes lost fetch cycles to the instruction-side cause that produced them, using a small, shared store instead of one counter set per in-flight branch. One shared group of three local counters records how many cycles fetch stalled on a first-level instruction cache miss, a second-level instruction cache miss or an instruction translation miss. The first instruction dispatched once such a stall has ended is tagged with a one-bit marker held in a vector indexed by reorder-buffer slot. When that tagged instruction completes, and has therefore proven to lie on the correct path, the block issues an add request that carries the three local counts to the global counters. In the same step it restarts the local counters and wipes every marker.

For each reorder-buffer slot that holds a branch, the block also keeps a penalty count. The count advances every cycle the branch is resident, except in cycles where the reorder buffer is full. When a mispredicted branch completes, its penalty is offered to the global branch counter. The whole structure is then reset, so instruction-side stalls seen on the wrong path are never reported. The surrounding core owns the reorder buffer; this block only sees slot numbers.

Top module: `fe_miss_tracker`

## Requirements
- R1: After a synchronous active-low reset, every local counter, penalty count, marker, branch-resident bit and the pending-stall state are zero, and neither add request is asserted.
- R2: `stall_cause` is encoded as 0 = no stall, 1 = first-level instruction cache, 2 = second-level instruction cache, 3 = instruction translation. Each cycle with a non-zero cause adds one to the matching shared counter, and a cycle with cause 0 leaves all three unchanged.
- R3: A dispatch in a cycle with cause 0 sets the marker of `disp_idx` only if at least one stall cycle has occurred since the last such dispatch. A dispatch during a stall cycle writes a clear marker, and any dispatch overwrites the marker of its slot.
- R4: A completion whose slot marker is set raises `add_iside_valid` in that same cycle, with the three counts as they stood before that cycle. From the next cycle the counters restart from zero, counting that cycle's stall cause, and all markers are clear except one written by a dispatch in the same cycle.
- R5: A completion of an unmarked slot raises no add request and leaves the counters unchanged.
- R6: A branch dispatched into a slot starts at penalty 0. Its penalty then grows by one in every following cycle in which `rob_full` is low, and holds while `rob_full` is high.
- R7: A mispredicted completion raises `add_br_valid` in the same cycle, with that slot's penalty if a branch is resident there and 0 otherwise. It then clears all markers, branch-resident bits, penalty tracking, the pending-stall state and all three local counters, and any dispatch or stall cause in that cycle has no effect.
- R8: When a marked completion and a mispredicted completion arrive in the same cycle, both add requests are issued in that cycle with their full values, and the full clear of R7 follows.
- R9: Local counters saturate at 2^CNT_W-1 and penalty counts saturate at 2^PEN_W-1; neither wraps.
- R10: A normal completion of a resident branch ends its tracking, so a later mispredicted completion naming that slot reports 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall_cause | input | 2 | Fetch stall cause this cycle (encoding in R2) |
| disp_valid | input | 1 | An instruction is dispatched this cycle |
| disp_idx | input | IDX_W | Reorder-buffer slot of the dispatched instruction |
| disp_is_branch | input | 1 | The dispatched instruction is a branch |
| cmpl_valid | input | 1 | An instruction completes normally this cycle |
| cmpl_idx | input | IDX_W | Slot of the completing instruction |
| mispred_valid | input | 1 | A mispredicted branch completes this cycle |
| mispred_idx | input | IDX_W | Slot of the mispredicted branch |
| rob_full | input | 1 | Reorder buffer is full this cycle |
| add_iside_valid | output | 1 | Add the three instruction-side amounts to the global counters |
| add_l1i_amt | output | CNT_W | First-level instruction cache stall cycles |
| add_l2i_amt | output | CNT_W | Second-level instruction cache stall cycles |
| add_itlb_amt | output | CNT_W | Instruction translation stall cycles |
| add_br_valid | output | 1 | Add `add_br_amt` to the global branch counter |
| add_br_amt | output | PEN_W | Penalty of the mispredicted branch |

## Verification
The hardest situation to reach is a cycle in which several things collide: a marked completion, a mispredicted completion, a dispatch and a live stall cause. In such a cycle, the precedence between restart, marker write and full clear decides every later count. Directed sequences build each collision on purpose. First they plant a marker after a known stall, then park a branch for a counted number of full and non-full cycles, then fire the completions together. Later marked completions then expose the cleared state at the ports. A long random phase with small counter widths and a shallow slot space reaches saturation and slot reuse, and checks them against a behavioural model.

// File: rtl/fmt_pkg.sv
// Shared definitions for the frontend miss tracker.
// Assumes: stall cause is a 2-bit code, 0 meaning no stall.
package fmt_pkg;
    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_L1I  = 2'd1,
        CAUSE_L2I  = 2'd2,
        CAUSE_ITLB = 2'd3
    } stall_cause_e;

    localparam int N_SIDE = 3;
endpackage

// File: rtl/fmt_side_counters.sv
// Shared instruction-side stall counters, one per stall cause.
// Assumes: restart and clear_all are single-cycle pulses; clear_all wins.
module fmt_side_counters #(
    parameter int CNT_W = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [1:0]                       stall_cause,
    input  logic                             restart,
    input  logic                             clear_all,
    output logic [fmt_pkg::N_SIDE*CNT_W-1:0] cnt_flat
);
    for (genvar k = 0; k < fmt_pkg::N_SIDE; k++) begin : g_side
        localparam logic [1:0] MY_CAUSE = 2'(k + 1);
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] base;

        // Value the counter continues from: zero after a reported group.
        assign base = restart ? '0 : cnt;

        // Count stall cycles of this cause, saturating at all-ones.
        always_ff @(posedge clk) begin
            if (!rst_n || clear_all) begin
                cnt <= '0;
            end else if (stall_cause == MY_CAUSE && base != '1) begin
                cnt <= base + 1'b1;
            end else begin
                cnt <= base;
            end
        end

        assign cnt_flat[k*CNT_W +: CNT_W] = cnt;
    end
endmodule

// File: rtl/fmt_miss_flags.sv
// Per-slot instruction-side miss markers plus the pending-stall state.
// Assumes: slot numbers are below ROB_DEPTH; clear_all overrides all writes.
module fmt_miss_flags #(
    parameter int ROB_DEPTH = 128,
    parameter int IDX_W     = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stall_active,
    input  logic                 disp_valid,
    input  logic [IDX_W-1:0]     disp_idx,
    input  logic                 clear_flags,
    input  logic                 clear_all,
    output logic [ROB_DEPTH-1:0] flags
);
    logic                 pending;
    logic                 mark;
    logic [ROB_DEPTH-1:0] flags_nxt;

    // A dispatch marks its slot when it is the first one after a stall.
    assign mark = disp_valid && !stall_active && pending;

    // Remember that a stall happened and no dispatch has claimed it yet.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_all) begin
            pending <= 1'b0;
        end else if (stall_active) begin
            pending <= 1'b1;
        end else if (disp_valid) begin
            pending <= 1'b0;
        end
    end

    // Next marker vector: group clear first, then the dispatch write.
    always_comb begin
        flags_nxt = clear_flags ? '0 : flags;
        if (disp_valid) begin
            flags_nxt[disp_idx] = mark;
        end
    end

    // Marker register.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_all) begin
            flags <= '0;
        end else begin
            flags <= flags_nxt;
        end
    end
endmodule

// File: rtl/fmt_branch_penalty.sv
// Per-slot branch residency and penalty counters.
// Assumes: a dispatch to a slot replaces whatever was tracked there.
module fmt_branch_penalty #(
    parameter int ROB_DEPTH = 128,
    parameter int IDX_W     = 7,
    parameter int PEN_W     = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear_all,
    input  logic                       rob_full,
    input  logic                       disp_valid,
    input  logic                       disp_is_branch,
    input  logic [IDX_W-1:0]           disp_idx,
    input  logic                       cmpl_valid,
    input  logic [IDX_W-1:0]           cmpl_idx,
    output logic [ROB_DEPTH-1:0]       br_live,
    output logic [ROB_DEPTH*PEN_W-1:0] pen_flat
);
    for (genvar s = 0; s < ROB_DEPTH; s++) begin : g_slot
        logic             disp_hit;
        logic             cmpl_hit;
        logic [PEN_W-1:0] pen;

        assign disp_hit = disp_valid && (disp_idx == IDX_W'(s));
        assign cmpl_hit = cmpl_valid && (cmpl_idx == IDX_W'(s));

        // Track whether a branch currently occupies this slot.
        always_ff @(posedge clk) begin
            if (!rst_n || clear_all) begin
                br_live[s] <= 1'b0;
            end else if (disp_hit) begin
                br_live[s] <= disp_is_branch;
            end else if (cmpl_hit) begin
                br_live[s] <= 1'b0;
            end
        end

        // Accumulate resident, non-full cycles with saturation.
        always_ff @(posedge clk) begin
            if (!rst_n || clear_all || disp_hit) begin
                pen <= '0;
            end else if (br_live[s] && !rob_full && pen != '1) begin
                pen <= pen + 1'b1;
            end
        end

        assign pen_flat[s*PEN_W +: PEN_W] = pen;
    end
endmodule

// File: rtl/fe_miss_tracker.sv
// Top of the shared frontend miss tracker: joins the side counters, the
// marker vector and the branch penalty store, and forms the add requests.
// Assumes: ROB_DEPTH is a power of two; one dispatch, one normal completion
// and one mispredicted completion at most per cycle.
module fe_miss_tracker #(
    parameter int ROB_DEPTH = 128,
    parameter int CNT_W     = 16,
    parameter int PEN_W     = 12,
    localparam int IDX_W    = $clog2(ROB_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       stall_cause,
    input  logic             disp_valid,
    input  logic [IDX_W-1:0] disp_idx,
    input  logic             disp_is_branch,
    input  logic             cmpl_valid,
    input  logic [IDX_W-1:0] cmpl_idx,
    input  logic             mispred_valid,
    input  logic [IDX_W-1:0] mispred_idx,
    input  logic             rob_full,
    output logic             add_iside_valid,
    output logic [CNT_W-1:0] add_l1i_amt,
    output logic [CNT_W-1:0] add_l2i_amt,
    output logic [CNT_W-1:0] add_itlb_amt,
    output logic             add_br_valid,
    output logic [PEN_W-1:0] add_br_amt
);
    import fmt_pkg::*;

    logic                             stall_active;
    logic                             flagged_hit;
    logic [ROB_DEPTH-1:0]             flag_vec;
    logic [ROB_DEPTH-1:0]             br_live;
    logic [ROB_DEPTH*PEN_W-1:0]       pen_flat;
    logic [N_SIDE*CNT_W-1:0]          cnt_flat;

    assign stall_active = (stall_cause != CAUSE_NONE);
    assign flagged_hit  = cmpl_valid && flag_vec[cmpl_idx];

    fmt_side_counters #(.CNT_W(CNT_W)) u_side (
        .clk         (clk),
        .rst_n       (rst_n),
        .stall_cause (stall_cause),
        .restart     (flagged_hit),
        .clear_all   (mispred_valid),
        .cnt_flat    (cnt_flat)
    );

    fmt_miss_flags #(.ROB_DEPTH(ROB_DEPTH), .IDX_W(IDX_W)) u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .stall_active (stall_active),
        .disp_valid   (disp_valid),
        .disp_idx     (disp_idx),
        .clear_flags  (flagged_hit),
        .clear_all    (mispred_valid),
        .flags        (flag_vec)
    );

    fmt_branch_penalty #(.ROB_DEPTH(ROB_DEPTH), .IDX_W(IDX_W), .PEN_W(PEN_W)) u_pen (
        .clk            (clk),
        .rst_n          (rst_n),
        .clear_all      (mispred_valid),
        .rob_full       (rob_full),
        .disp_valid     (disp_valid),
        .disp_is_branch (disp_is_branch),
        .disp_idx       (disp_idx),
        .cmpl_valid     (cmpl_valid),
        .cmpl_idx       (cmpl_idx),
        .br_live        (br_live),
        .pen_flat       (pen_flat)
    );

    // Instruction-side add request: fires on a marked completion.
    assign add_iside_valid = flagged_hit;
    assign add_l1i_amt     = cnt_flat[0*CNT_W +: CNT_W];
    assign add_l2i_amt     = cnt_flat[1*CNT_W +: CNT_W];
    assign add_itlb_amt    = cnt_flat[2*CNT_W +: CNT_W];

    // Branch add request: penalty of the named slot if a branch lives there.
    assign add_br_valid = mispred_valid;
    assign add_br_amt   = br_live[mispred_idx] ? pen_flat[mispred_idx*PEN_W +: PEN_W] : '0;
endmodule

// File: rtl/fmt_checker.sv
// Property checker for the shared frontend miss tracker, bound to the top.
// Assumes: reset is applied for at least one clock before use.
module fmt_checker #(
    parameter int ROB_DEPTH = 128,
    parameter int CNT_W     = 16,
    parameter int PEN_W     = 12
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [1:0]                  stall_cause,
    input logic                        disp_valid,
    input logic                        cmpl_valid,
    input logic                        mispred_valid,
    input logic                        rob_full,
    input logic                        add_iside_valid,
    input logic [ROB_DEPTH-1:0]        flags,
    input logic [ROB_DEPTH-1:0]        br_live,
    input logic [3*CNT_W-1:0]          cnt_flat,
    input logic [ROB_DEPTH*PEN_W-1:0]  pen_flat
);
    AST_ADD_NEEDS_CMPL: assert property (@(posedge clk) disable iff (!rst_n)
        add_iside_valid |-> cmpl_valid); // R4

    AST_MARKERS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        add_iside_valid |=> ($countones(flags) <= 1)); // R4

    AST_MISPRED_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
        mispred_valid |=> (flags == '0 && br_live == '0 && cnt_flat == '0)); // R7

    AST_PEN_HOLD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (rob_full && !disp_valid && !mispred_valid) |=> $stable(pen_flat)); // R6

    AST_NO_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_cause == 2'd0 && !add_iside_valid && !mispred_valid) |=> $stable(cnt_flat)); // R2

    for (genvar k = 0; k < 3; k++) begin : g_sat
        AST_SIDE_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_flat[k*CNT_W +: CNT_W] == '1 && !add_iside_valid && !mispred_valid)
            |=> (cnt_flat[k*CNT_W +: CNT_W] == '1)); // R9
    end
endmodule

bind fe_miss_tracker fmt_checker #(
    .ROB_DEPTH (ROB_DEPTH),
    .CNT_W     (CNT_W),
    .PEN_W     (PEN_W)
) u_fmt_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .stall_cause     (stall_cause),
    .disp_valid      (disp_valid),
    .cmpl_valid      (cmpl_valid),
    .mispred_valid   (mispred_valid),
    .rob_full        (rob_full),
    .add_iside_valid (add_iside_valid),
    .flags           (flag_vec),
    .br_live         (br_live),
    .cnt_flat        (cnt_flat),
    .pen_flat        (pen_flat)
);

// File: tb/test_fe_miss_tracker.sv
// Self-checking bench: directed collisions plus a random phase, compared
// every cycle against a behavioural reference model.
module test_fe_miss_tracker;
    localparam int ROB  = 16;
    localparam int CW   = 6;
    localparam int PW   = 5;
    localparam int IW   = 4;
    localparam int MAXC = (1 << CW) - 1;
    localparam int MAXP = (1 << PW) - 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    cause;
    logic          disp_v, disp_b, cmpl_v, misp_v, full;
    logic [IW-1:0] disp_i, cmpl_i, misp_i;
    logic          add_iside_valid, add_br_valid;
    logic [CW-1:0] add_l1i_amt, add_l2i_amt, add_itlb_amt;
    logic [PW-1:0] add_br_amt;

    int total = 0;
    int bad   = 0;

    int m_loc [3];
    bit m_flag [ROB];
    bit m_brv  [ROB];
    int m_pen  [ROB];
    bit m_pend;

    always #4 clk = ~clk;

    fe_miss_tracker #(.ROB_DEPTH(ROB), .CNT_W(CW), .PEN_W(PW)) i_fe_miss_tracker (
        .clk             (clk),
        .rst_n           (rst_n),
        .stall_cause     (cause),
        .disp_valid      (disp_v),
        .disp_idx        (disp_i),
        .disp_is_branch  (disp_b),
        .cmpl_valid      (cmpl_v),
        .cmpl_idx        (cmpl_i),
        .mispred_valid   (misp_v),
        .mispred_idx     (misp_i),
        .rob_full        (full),
        .add_iside_valid (add_iside_valid),
        .add_l1i_amt     (add_l1i_amt),
        .add_l2i_amt     (add_l2i_amt),
        .add_itlb_amt    (add_itlb_amt),
        .add_br_valid    (add_br_valid),
        .add_br_amt      (add_br_amt)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Compare all outputs with the reference model.
    task automatic compare();
        chk("R4 iside valid", 32'(add_iside_valid), 32'(cmpl_v && m_flag[cmpl_i]));
        chk("R2 l1i amount", 32'(add_l1i_amt), m_loc[0]);
        chk("R2 l2i amount", 32'(add_l2i_amt), m_loc[1]);
        chk("R2 itlb amount", 32'(add_itlb_amt), m_loc[2]);
        chk("R7 br valid", 32'(add_br_valid), 32'(misp_v));
        chk("R6 br amount", 32'(add_br_amt), m_brv[misp_i] ? m_pen[misp_i] : 0);
    endtask

    // Advance the reference model by one clock.
    task automatic model_step();
        if (!rst_n || misp_v) begin
            foreach (m_loc[k]) m_loc[k] = 0;
            for (int s = 0; s < ROB; s++) begin
                m_flag[s] = 0; m_brv[s] = 0; m_pen[s] = 0;
            end
            m_pend = 0;
        end else begin
            bit hit;
            hit = cmpl_v && m_flag[cmpl_i];
            if (hit) begin
                foreach (m_loc[k]) m_loc[k] = 0;
                for (int s = 0; s < ROB; s++) m_flag[s] = 0;
            end
            if (cause != 2'd0 && m_loc[int'(cause) - 1] < MAXC) m_loc[int'(cause) - 1]++;
            for (int s = 0; s < ROB; s++)
                if (m_brv[s] && !full && m_pen[s] < MAXP) m_pen[s]++;
            if (cmpl_v) m_brv[cmpl_i] = 0;
            if (disp_v) begin
                m_brv[disp_i]  = disp_b;
                m_pen[disp_i]  = 0;
                m_flag[disp_i] = m_pend && (cause == 2'd0);
            end
            if (cause != 2'd0) m_pend = 1;
            else if (disp_v) m_pend = 0;
        end
    endtask

    task automatic cyc();
        #1;
        if (rst_n) compare();
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic clr_in();
        cause = 2'd0; disp_v = 0; disp_b = 0; disp_i = '0;
        cmpl_v = 0; cmpl_i = '0; misp_v = 0; misp_i = '0; full = 0;
    endtask

    task automatic idle(input int n);
        clr_in();
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic disp(input int idx, input bit br);
        clr_in(); disp_v = 1; disp_i = IW'(idx); disp_b = br; cyc();
    endtask

    task automatic stall(input logic [1:0] c, input int n);
        clr_in(); cause = c;
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin
        #1600000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 0;
        clr_in();
        @(negedge clk);
        repeat (3) cyc();
        rst_n = 1;
        #1;
        chk("R1 iside after reset", 32'(add_iside_valid), 0);
        chk("R1 br after reset", 32'(add_br_valid), 0);
        chk("R1 l1i after reset", 32'(add_l1i_amt), 0);
        cyc();

        // R2 R3 R4 R5: counted stalls, marking, reporting, restart.
        stall(2'd1, 5);
        stall(2'd2, 3);
        clr_in(); cause = 2'd3; disp_v = 1; disp_i = 4'd1; cyc();
        stall(2'd3, 1);
        disp(2, 0);
        disp(3, 0);
        clr_in(); cmpl_v = 1; cmpl_i = 4'd1; #1;
        chk("R3 dispatch during stall unmarked", 32'(add_iside_valid), 0); cyc();
        clr_in(); cmpl_v = 1; cmpl_i = 4'd3; #1;
        chk("R5 unmarked completion", 32'(add_iside_valid), 0); cyc();
        clr_in(); cmpl_v = 1; cmpl_i = 4'd2; cause = 2'd1; #1;
        chk("R4 marked completion", 32'(add_iside_valid), 1);
        chk("R2 l1i count", 32'(add_l1i_amt), 5);
        chk("R2 l2i count", 32'(add_l2i_amt), 3);
        chk("R2 itlb count", 32'(add_itlb_amt), 2);
        cyc();
        clr_in(); #1;
        chk("R4 restart counts same-cycle stall", 32'(add_l1i_amt), 1);
        chk("R4 restart clears l2i", 32'(add_l2i_amt), 0);
        cyc();

        // R6 R7: penalty with full cycles, then mispredict wipes all.
        stall(2'd2, 2);
        disp(9, 0);
        disp(5, 1);
        idle(4);
        clr_in(); full = 1; cyc(); cyc();
        idle(3);
        clr_in(); misp_v = 1; misp_i = 4'd5; cause = 2'd2; disp_v = 1; disp_i = 4'd6; #1;
        chk("R7 br valid", 32'(add_br_valid), 1);
        chk("R6 penalty skips full cycles", 32'(add_br_amt), 7);
        cyc();
        clr_in(); cmpl_v = 1; cmpl_i = 4'd9; #1;
        chk("R7 marker wiped", 32'(add_iside_valid), 0); cyc();
        stall(2'd1, 1);
        disp(4, 0);
        clr_in(); cmpl_v = 1; cmpl_i = 4'd4; #1;
        chk("R7 l1i after wipe", 32'(add_l1i_amt), 1);
        chk("R7 l2i wiped, same-cycle stall ignored", 32'(add_l2i_amt), 0);
        cyc();

        // R8: marked and mispredicted completions together.
        stall(2'd3, 2);
        disp(7, 0);
        disp(8, 1);
        idle(2);
        clr_in(); cmpl_v = 1; cmpl_i = 4'd7; misp_v = 1; misp_i = 4'd8; #1;
        chk("R8 iside valid", 32'(add_iside_valid), 1);
        chk("R8 itlb amount", 32'(add_itlb_amt), 2);
        chk("R8 br valid", 32'(add_br_valid), 1);
        chk("R8 br amount", 32'(add_br_amt), 2);
        cyc();
        disp(10, 0);
        clr_in(); cmpl_v = 1; cmpl_i = 4'd10; #1;
        chk("R8 pending cleared", 32'(add_iside_valid), 0); cyc();
        stall(2'd1, 1);
        disp(11, 0);
        clr_in(); cmpl_v = 1; cmpl_i = 4'd11; #1;
        chk("R8 itlb cleared", 32'(add_itlb_amt), 0); cyc();

        // R10: normal branch completion ends tracking.
        disp(12, 1);
        idle(3);
        clr_in(); cmpl_v = 1; cmpl_i = 4'd12; cyc();
        clr_in(); misp_v = 1; misp_i = 4'd12; #1;
        chk("R10 completed branch reports zero", 32'(add_br_amt), 0); cyc();

        // R9: saturation of both counter kinds.
        stall(2'd2, 70);
        disp(0, 0);
        disp(13, 1);
        idle(40);
        clr_in(); cmpl_v = 1; cmpl_i = 4'd0; #1;
        chk("R9 side counter saturates", 32'(add_l2i_amt), MAXC); cyc();
        clr_in(); misp_v = 1; misp_i = 4'd13; #1;
        chk("R9 penalty saturates", 32'(add_br_amt), MAXP); cyc();

        // Random phase against the model.
        for (int i = 0; i < 3000; i++) begin
            clr_in();
            cause  = ($urandom_range(0, 2) == 0) ? 2'($urandom_range(1, 3)) : 2'd0;
            disp_v = 1'($urandom_range(0, 1));
            disp_i = IW'($urandom_range(0, ROB - 1));
            disp_b = 1'($urandom_range(0, 1));
            cmpl_v = 1'($urandom_range(0, 1));
            cmpl_i = IW'($urandom_range(0, ROB - 1));
            misp_v = ($urandom_range(0, 39) == 0);
            misp_i = IW'($urandom_range(0, ROB - 1));
            full   = ($urandom_range(0, 3) == 0);
            cyc();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule